// File: doc/BRIEF.md
# AC'97 Receive Slot Capture Router

This block sits on the input serial line of an AC'97 codec link. Once per bit clock it samples the serial input and the frame sync. It splits each incoming frame into the 16-bit tag slot and twelve 20-bit data slots. Four independent receive channels then each pick out the data slots they were set up for, cut each sample to a configured width and queue it in a private FIFO for the host to read.

A channel stores a slot only under three conditions: the slot is in its selection mask, the codec marked that slot valid in the tag slot, and both of the channel's enables are set. Each channel has a sticky overrun flag, raised when a sample meets a full FIFO. It also has a sticky idle-timeout interrupt, raised when samples have sat unread for a programmed number of frames. The block also keeps the codec's per-slot data-request bits from slot 1 for the transmit side.

Framing is handled by a three-state machine:
- `ST_HUNT` waits for a frame.
- `ST_TAG` shifts in the tag slot.
- `ST_DATA` shifts in the data slots.

The transitions are:
- HUNT→TAG on a sync rising edge.
- TAG→DATA after the 16th tag bit.
- DATA→HUNT after the last bit of slot 12.
- Any state→TAG on a sync rising edge, which restarts the frame.

Top module: `ac97_rx_router`

## Requirements
- R1: The sample taken in the first cycle where `sync` is 1 after being 0 is bit 15 (MSB) of the tag slot. Sixteen tag bits follow, MSB first, then slots 1 to 12 of 20 bits each, MSB first. A new sync rising edge restarts framing at any point.
- R2: Channel c stores only the slots whose bit is set in its 12-bit mask `cfg_slot_mask[c*12 +: 12]`, where bit i selects slot i+1. Stored samples enter the FIFO in slot order, and several channels may store the same slot.
- R3: With width field W (`cfg_width[c*5 +: 5]`), the stored word is the top W bits of the 20-bit slot, right-aligned with zeros above. W of 0 or above 20 is treated as 20.
- R4: Slot n is stored only when tag-slot bit 15−n is 1, so bit 14 is slot 1 and bit 3 is slot 12.
- R5: A channel stores nothing unless both `cfg_chan_en[c]` and `cfg_fifo_en[c]` are 1.
- R6: `slot_req` takes bits 11:2 of slot 1 every frame, whatever that slot's tag bit. `slot_req[9]` is the request for slot 3 and `slot_req[0]` is the request for slot 12.
- R7: A sample meeting a full FIFO is dropped and sets `overrun[c]`. The flag stays set until `flag_clr[c]` is 1 for a cycle.
- R8: A per-channel frame counter restarts on every FIFO write or read and advances on each sync rising edge. When it reaches a nonzero `cfg_timeout` while the FIFO holds data, `timeout_irq[c]` sets and stays set until `flag_clr[c]`. A limit of 0 disables the interrupt.
- R9: During and right after reset, all FIFOs read empty, and `overrun`, `timeout_irq` and `slot_req` are zero.
- R10: `rd_data` shows the oldest entry whenever `rd_empty` is 0, and `rd_en` removes it on the clock edge. A stored sample appears two cycles after the cycle that samples its slot's last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all sampling on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sync | input | 1 | Frame sync from the link |
| sdata_in | input | 1 | Serial input data from the codec |
| cfg_slot_mask | input | NCH*12 | Per-channel slot selection masks |
| cfg_width | input | NCH*5 | Per-channel kept bit count |
| cfg_fifo_en | input | NCH | Per-channel FIFO enable |
| cfg_chan_en | input | NCH | Per-channel receive enable |
| cfg_timeout | input | NCH*TO_W | Per-channel idle limit in frames |
| flag_clr | input | NCH | Clears the channel's sticky flags |
| rd_en | input | NCH | Removes the head entry of the channel FIFO |
| rd_data | output | NCH*20 | Head entry of each channel FIFO |
| rd_empty | output | NCH | Channel FIFO is empty |
| timeout_irq | output | NCH | Sticky idle-timeout interrupt |
| overrun | output | NCH | Sticky overrun flag |
| slot_req | output | 10 | Data-request bits for slots 3 to 12 |

## Verification
Each result has its own latency, and the checks are placed to match it:
- A captured sample reaches the FIFO head two cycles after its slot's last bit is sampled.
- `overrun` follows that store attempt by one edge.
- `slot_req` updates one cycle after the last bit of slot 1.
- `timeout_irq` rises two cycles after the sync edge that brings the counter to its limit.

The bench drives bits and samples outputs on the falling clock edge. Its monitor compares each FIFO head with the scoreboard as soon as `rd_empty` drops. Flag and request checks are made only after several idle cycles past the end of a frame, so every pending register stage has settled.

// File: rtl/ac97rx_pkg.sv
package ac97rx_pkg;
    localparam int SLOTS   = 12;
    localparam int SLOT_W  = 20;
    localparam int TAG_W   = 16;
    localparam int REQ_W   = 10;
    localparam int WID_W   = 5;
    localparam int SIDX_W  = 4;
    localparam int BCNT_W  = 5;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_TAG,
        ST_DATA
    } rx_state_e;
endpackage

// File: rtl/ac97rx_deser.sv
module ac97rx_deser
    import ac97rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sync,
    input  logic                sdata,
    output logic                frame_tick,
    output logic                slot_vld,
    output logic [SIDX_W-1:0]   slot_idx,
    output logic [SLOT_W-1:0]   slot_data,
    output logic                slot_tag,
    output logic [REQ_W-1:0]    slot_req
);
    rx_state_e            state, state_nxt;
    logic                 sync_q;
    logic                 sync_rise;
    logic [SLOT_W-1:0]    shreg;
    logic [SLOT_W-1:0]    word;
    logic [BCNT_W-1:0]    bit_cnt;
    logic [SIDX_W-1:0]    slot_num;
    logic [SIDX_W-1:0]    tag_sel;
    logic [SLOTS-1:0]     tags;
    logic [SLOTS-1:0]     tags_new;

    assign sync_rise = sync & ~sync_q;
    assign word      = {shreg[SLOT_W-2:0], sdata};
    assign tag_sel   = slot_num - SIDX_W'(1);

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            tags_new[i] = word[TAG_W-2-i];
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HUNT: if (sync_rise) state_nxt = ST_TAG;
            ST_TAG: begin
                if (sync_rise)                           state_nxt = ST_TAG;
                else if (bit_cnt == BCNT_W'(TAG_W - 1))  state_nxt = ST_DATA;
            end
            ST_DATA: begin
                if (sync_rise) state_nxt = ST_TAG;
                else if (bit_cnt == BCNT_W'(SLOT_W - 1) && slot_num == SIDX_W'(SLOTS))
                    state_nxt = ST_HUNT;
            end
            default: state_nxt = ST_HUNT;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q     <= 1'b0;
            shreg      <= '0;
            bit_cnt    <= '0;
            slot_num   <= '0;
            tags       <= '0;
            frame_tick <= 1'b0;
            slot_vld   <= 1'b0;
            slot_idx   <= '0;
            slot_data  <= '0;
            slot_tag   <= 1'b0;
            slot_req   <= '0;
        end else begin
            sync_q     <= sync;
            shreg      <= word;
            frame_tick <= sync_rise;
            slot_vld   <= 1'b0;
            if (sync_rise) begin
                bit_cnt <= BCNT_W'(1);
            end else begin
                unique case (state)
                    ST_HUNT: bit_cnt <= '0;
                    ST_TAG: begin
                        if (bit_cnt == BCNT_W'(TAG_W - 1)) begin
                            tags     <= tags_new;
                            bit_cnt  <= '0;
                            slot_num <= SIDX_W'(1);
                        end else begin
                            bit_cnt <= bit_cnt + BCNT_W'(1);
                        end
                    end
                    ST_DATA: begin
                        if (bit_cnt == BCNT_W'(SLOT_W - 1)) begin
                            slot_vld  <= 1'b1;
                            slot_idx  <= slot_num;
                            slot_data <= word;
                            slot_tag  <= tags[tag_sel];
                            if (slot_num == SIDX_W'(1)) slot_req <= word[REQ_W+1:2];
                            bit_cnt   <= '0;
                            slot_num  <= slot_num + SIDX_W'(1);
                        end else begin
                            bit_cnt <= bit_cnt + BCNT_W'(1);
                        end
                    end
                    default: bit_cnt <= '0;
                endcase
            end
        end
    end

    AST_SLOT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld |=> !slot_vld);                                        // R1
    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld |-> (slot_idx >= SIDX_W'(1) && slot_idx <= SIDX_W'(SLOTS))); // R1
endmodule

// File: rtl/ac97rx_fifo.sv
module ac97rx_fifo #(
    parameter int W     = 20,
    parameter int DEPTH = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [W-1:0]              wdata,
    input  logic                      pop,
    output logic [W-1:0]              rdata,
    output logic                      empty,
    output logic                      full,
    output logic [$clog2(DEPTH):0]    level
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;

    assign empty = (level == '0);
    assign full  = (level == (AW+1)'(DEPTH));
    assign rdata = mem[rp];

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (push) wp <= wp + AW'(1);
            if (pop)  rp <= rp + AW'(1);
            unique case ({push, pop})
                2'b10:   level <= level + (AW+1)'(1);
                2'b01:   level <= level - (AW+1)'(1);
                default: level <= level;
            endcase
        end
    end

    AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop |=> !empty);                                        // R10
endmodule

// File: rtl/ac97rx_chan.sv
module ac97rx_chan
    import ac97rx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TO_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_tick,
    input  logic               slot_vld,
    input  logic [SIDX_W-1:0]  slot_idx,
    input  logic [SLOT_W-1:0]  slot_data,
    input  logic               slot_tag,
    input  logic [SLOTS-1:0]   cfg_mask,
    input  logic [WID_W-1:0]   cfg_width,
    input  logic               cfg_fifo_en,
    input  logic               cfg_chan_en,
    input  logic [TO_W-1:0]    cfg_timeout,
    input  logic               flag_clr,
    input  logic               rd_en,
    output logic [SLOT_W-1:0]  rd_data,
    output logic               rd_empty,
    output logic               irq,
    output logic               overrun
);
    localparam int LW = $clog2(DEPTH) + 1;

    logic [SIDX_W-1:0] sel;
    logic [WID_W-1:0]  eff_w;
    logic [WID_W-1:0]  shamt;
    logic [SLOT_W-1:0] sample;
    logic              store, push, pop, full;
    logic [LW-1:0]     level;
    logic [TO_W-1:0]   idle_cnt;

    assign sel    = slot_idx - SIDX_W'(1);
    assign eff_w  = (cfg_width == '0 || cfg_width > WID_W'(SLOT_W)) ? WID_W'(SLOT_W) : cfg_width;
    assign shamt  = WID_W'(SLOT_W) - eff_w;
    assign sample = slot_data >> shamt;
    assign store  = slot_vld & slot_tag & cfg_chan_en & cfg_fifo_en & cfg_mask[sel];
    assign push   = store & ~full;
    assign pop    = rd_en & ~rd_empty;

    ac97rx_fifo #(.W(SLOT_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (sample),
        .pop   (pop),
        .rdata (rd_data),
        .empty (rd_empty),
        .full  (full),
        .level (level)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            irq      <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            if (push || pop)                       idle_cnt <= '0;
            else if (frame_tick && idle_cnt != '1) idle_cnt <= idle_cnt + TO_W'(1);

            if (flag_clr)                          overrun <= 1'b0;
            else if (store && full)                overrun <= 1'b1;

            if (flag_clr)                          irq <= 1'b0;
            else if (cfg_timeout != '0 && idle_cnt >= cfg_timeout && !rd_empty)
                                                   irq <= 1'b1;
        end
    end

    AST_DROP_FLAGS_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        store && full && !flag_clr |=> overrun);                         // R7
    AST_GATED_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_chan_en && cfg_fifo_en) |=> level <= $past(level));         // R5
    AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(!rd_empty));                                // R8
endmodule

// File: rtl/ac97_rx_router.sv
module ac97_rx_router
    import ac97rx_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int DEPTH = 8,
    parameter int TO_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sync,
    input  logic                    sdata_in,
    input  logic [NCH*SLOTS-1:0]    cfg_slot_mask,
    input  logic [NCH*WID_W-1:0]    cfg_width,
    input  logic [NCH-1:0]          cfg_fifo_en,
    input  logic [NCH-1:0]          cfg_chan_en,
    input  logic [NCH*TO_W-1:0]     cfg_timeout,
    input  logic [NCH-1:0]          flag_clr,
    input  logic [NCH-1:0]          rd_en,
    output logic [NCH*SLOT_W-1:0]   rd_data,
    output logic [NCH-1:0]          rd_empty,
    output logic [NCH-1:0]          timeout_irq,
    output logic [NCH-1:0]          overrun,
    output logic [REQ_W-1:0]        slot_req
);
    logic              frame_tick, slot_vld, slot_tag;
    logic [SIDX_W-1:0] slot_idx;
    logic [SLOT_W-1:0] slot_data;

    ac97rx_deser u_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync       (sync),
        .sdata      (sdata_in),
        .frame_tick (frame_tick),
        .slot_vld   (slot_vld),
        .slot_idx   (slot_idx),
        .slot_data  (slot_data),
        .slot_tag   (slot_tag),
        .slot_req   (slot_req)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        ac97rx_chan #(.DEPTH(DEPTH), .TO_W(TO_W)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .frame_tick  (frame_tick),
            .slot_vld    (slot_vld),
            .slot_idx    (slot_idx),
            .slot_data   (slot_data),
            .slot_tag    (slot_tag),
            .cfg_mask    (cfg_slot_mask[c*SLOTS +: SLOTS]),
            .cfg_width   (cfg_width[c*WID_W +: WID_W]),
            .cfg_fifo_en (cfg_fifo_en[c]),
            .cfg_chan_en (cfg_chan_en[c]),
            .cfg_timeout (cfg_timeout[c*TO_W +: TO_W]),
            .flag_clr    (flag_clr[c]),
            .rd_en       (rd_en[c]),
            .rd_data     (rd_data[c*SLOT_W +: SLOT_W]),
            .rd_empty    (rd_empty[c]),
            .irq         (timeout_irq[c]),
            .overrun     (overrun[c])
        );
    end
endmodule

// File: tb/test_ac97_rx_router.sv
module test_ac97_rx_router;
    localparam int NCH   = 4;
    localparam int DEPTH = 8;
    localparam int TO_W  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync = 1'b0;
    logic sdata_in = 1'b0;
    logic [NCH*12-1:0]   cfg_slot_mask = '0;
    logic [NCH*5-1:0]    cfg_width = '0;
    logic [NCH-1:0]      cfg_fifo_en = '0;
    logic [NCH-1:0]      cfg_chan_en = '0;
    logic [NCH*TO_W-1:0] cfg_timeout = '0;
    logic [NCH-1:0]      flag_clr = '0;
    logic [NCH-1:0]      rd_en = '0;
    logic [NCH*20-1:0]   rd_data;
    logic [NCH-1:0]      rd_empty, timeout_irq, overrun;
    logic [9:0]          slot_req;

    always #10 clk = ~clk;

    ac97_rx_router #(.NCH(NCH), .DEPTH(DEPTH), .TO_W(TO_W)) i_ac97_rx_router (
        .clk(clk), .rst_n(rst_n), .sync(sync), .sdata_in(sdata_in),
        .cfg_slot_mask(cfg_slot_mask), .cfg_width(cfg_width),
        .cfg_fifo_en(cfg_fifo_en), .cfg_chan_en(cfg_chan_en),
        .cfg_timeout(cfg_timeout), .flag_clr(flag_clr), .rd_en(rd_en),
        .rd_data(rd_data), .rd_empty(rd_empty), .timeout_irq(timeout_irq),
        .overrun(overrun), .slot_req(slot_req)
    );

    typedef struct packed { logic [1:0] ch; logic [19:0] d; } item_t;
    item_t       sb_q[$];
    int          n_checks = 0;
    int          n_fail = 0;
    bit          drain = 1'b0;
    bit          done = 1'b0;
    logic [11:0] tags;
    logic [19:0] fr_slot [12];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] trim(input logic [19:0] d, input logic [4:0] w);
        int e = (w == 0 || w > 20) ? 20 : int'(w);
        return d >> (20 - e);
    endfunction

    function automatic int qcount(input int c);
        int n = 0;
        foreach (sb_q[i]) if (sb_q[i].ch == 2'(c)) n++;
        return n;
    endfunction

    task automatic set_chan(input int c, input logic [11:0] m, input logic [4:0] w,
                            input bit fen, input bit cen, input logic [7:0] to);
        cfg_slot_mask[c*12 +: 12] = m;
        cfg_width[c*5 +: 5]       = w;
        cfg_fifo_en[c]            = fen;
        cfg_chan_en[c]            = cen;
        cfg_timeout[c*TO_W +: TO_W] = to;
    endtask

    task automatic fill(input logic [7:0] seed);
        for (int s = 0; s < 12; s++)
            fr_slot[s] = {seed, 4'(s), 8'h00} ^ (20'h9E37B * (s + 1)) ^ {12'h0, seed};
    endtask

    // driver: pushes expected samples, then serialises the frame
    task automatic send_frame();
        logic [15:0] w0;
        for (int s = 0; s < 12; s++)
            for (int c = 0; c < NCH; c++)
                if (cfg_chan_en[c] && cfg_fifo_en[c] && cfg_slot_mask[c*12 + s] && tags[s]) begin
                    if (drain || qcount(c) < DEPTH)
                        sb_q.push_back('{ch: 2'(c), d: trim(fr_slot[s], cfg_width[c*5 +: 5])});
                end
        w0 = 16'h8000;
        for (int i = 0; i < 12; i++) w0[14-i] = tags[i];
        for (int b = 15; b >= 0; b--) begin
            @(negedge clk); sync = 1'b1; sdata_in = w0[b];
        end
        for (int s = 0; s < 12; s++)
            for (int b = 19; b >= 0; b--) begin
                @(negedge clk); sync = 1'b0; sdata_in = fr_slot[s][b];
            end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sync = 1'b0; sdata_in = 1'b0;
        end
    endtask

    // monitor: compares each FIFO head with the scoreboard (R2 R3 R10)
    always @(negedge clk) begin
        rd_en = '0;
        if (drain && rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                if (!rd_empty[c]) begin
                    int hit = -1;
                    foreach (sb_q[i]) if (hit < 0 && sb_q[i].ch == 2'(c)) hit = i;
                    if (hit < 0) begin
                        chk(1'b0, "R2 unexpected sample", 32'(rd_data[c*20 +: 20]), 32'hFFFFFFFF);
                    end else begin
                        chk(rd_data[c*20 +: 20] === sb_q[hit].d, "R2/R3/R10 sample value",
                            32'(rd_data[c*20 +: 20]), 32'(sb_q[hit].d));
                        sb_q.delete(hit);
                    end
                    rd_en[c] = 1'b1;
                end
            end
        end
    end

    initial begin
        #(20 * 190000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(rd_empty === 4'hF, "R9 empty in reset", 32'(rd_empty), 32'hF);
        chk(overrun === 4'h0 && timeout_irq === 4'h0, "R9 flags in reset",
            32'({overrun, timeout_irq}), 32'h0);
        chk(slot_req === 10'h0, "R9 slot_req in reset", 32'(slot_req), 32'h0);
        rst_n = 1'b1;
        idle(3);
        chk(rd_empty === 4'hF, "R9 empty after reset", 32'(rd_empty), 32'hF);

        // R1 R2 R3: routing with several widths
        set_chan(0, 12'h00C, 5'd20, 1, 1, 8'd0);
        set_chan(1, 12'h004, 5'd16, 1, 1, 8'd0);
        set_chan(2, 12'h800, 5'd1,  1, 1, 8'd0);
        set_chan(3, 12'h010, 5'd0,  1, 1, 8'd0);
        drain = 1'b1;
        tags = 12'hFFF;
        fill(8'h11); send_frame();
        fill(8'hC3); send_frame();
        idle(6);
        chk(slot_req === fr_slot[0][11:2], "R6 slot request bits", 32'(slot_req), 32'(fr_slot[0][11:2]));
        chk(sb_q.size() == 0, "R2 all routed samples seen", 32'(sb_q.size()), 32'h0);

        // R4: tag gating, slots 4 and 5 invalid
        tags = 12'hFE7;
        fill(8'h5A); send_frame();
        idle(6);
        chk(rd_empty === 4'hF && sb_q.size() == 0, "R4 untagged slots not stored",
            32'(sb_q.size()), 32'h0);
        chk(slot_req === fr_slot[0][11:2], "R6 request bits ignore tag", 32'(slot_req), 32'(fr_slot[0][11:2]));

        // R5: one channel with FIFO off, one with receive off
        tags = 12'hFFF;
        set_chan(1, 12'h004, 5'd16, 0, 1, 8'd0);
        set_chan(3, 12'h010, 5'd0,  1, 0, 8'd0);
        fill(8'h77); send_frame();
        idle(6);
        chk(rd_empty === 4'hF && sb_q.size() == 0, "R5 disabled channels store nothing",
            32'(sb_q.size()), 32'h0);

        // R3: further widths, including above 20
        set_chan(1, 12'h004, 5'd8,  1, 1, 8'd0);
        set_chan(2, 12'h800, 5'd25, 1, 1, 8'd0);
        fill(8'hE9); send_frame();
        idle(6);
        chk(sb_q.size() == 0, "R3 width variants delivered", 32'(sb_q.size()), 32'h0);

        // R7: overrun on channel 0 only
        set_chan(0, 12'hFFC, 5'd20, 1, 1, 8'd0);
        set_chan(1, 12'h000, 5'd20, 1, 0, 8'd0);
        set_chan(2, 12'h000, 5'd20, 1, 0, 8'd0);
        set_chan(3, 12'h000, 5'd20, 1, 0, 8'd0);
        drain = 1'b0;
        fill(8'h3C); send_frame();
        idle(6);
        chk(overrun === 4'b0001, "R7 overrun on full FIFO", 32'(overrun), 32'h1);
        chk(qcount(0) == DEPTH, "R7 only DEPTH samples kept", 32'(qcount(0)), 32'(DEPTH));
        drain = 1'b1;
        idle(20);
        chk(overrun === 4'b0001, "R7 overrun sticky", 32'(overrun), 32'h1);
        chk(sb_q.size() == 0, "R7 kept samples in order", 32'(sb_q.size()), 32'h0);
        @(negedge clk); flag_clr = 4'hF;
        @(negedge clk); flag_clr = 4'h0;
        @(negedge clk);
        chk(overrun === 4'b0000, "R7 overrun cleared", 32'(overrun), 32'h0);

        // R8: idle timeout after three frame starts
        set_chan(0, 12'h004, 5'd20, 1, 1, 8'd3);
        set_chan(1, 12'h000, 5'd20, 1, 1, 8'd3);
        drain = 1'b0;
        tags = 12'hFFF; fill(8'h21); send_frame();
        tags = 12'h000; fill(8'h22); send_frame();
        fill(8'h23); send_frame();
        idle(6);
        chk(timeout_irq === 4'b0000, "R8 no irq before limit", 32'(timeout_irq), 32'h0);
        fill(8'h24); send_frame();
        idle(6);
        chk(timeout_irq === 4'b0001, "R8 irq at limit with data", 32'(timeout_irq), 32'h1);
        drain = 1'b1;
        idle(6);
        chk(timeout_irq === 4'b0001, "R8 irq sticky after read", 32'(timeout_irq), 32'h1);
        @(negedge clk); flag_clr = 4'hF;
        @(negedge clk); flag_clr = 4'h0;
        for (int k = 0; k < 4; k++) begin fill(8'(8'h40 + k)); send_frame(); end
        idle(6);
        chk(timeout_irq === 4'b0000, "R8 empty FIFO raises no irq", 32'(timeout_irq), 32'h0);

        // R1: resync mid-frame restarts framing
        tags = 12'hFFF;
        fill(8'h66);
        for (int b = 0; b < 50; b++) begin @(negedge clk); sync = (b < 16); sdata_in = 1'b1; end
        idle(2);
        send_frame();
        idle(6);
        chk(sb_q.size() == 0 && rd_empty === 4'hF, "R1 resync then clean frame",
            32'(sb_q.size()), 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule